// File: doc/BRIEF.md
# Three-Tap FIR Filter with Loadable Coefficients

This block filters a stream of unsigned 12-bit samples. It takes one new sample on every clock. A three-register delay line keeps the newest sample and the two before it. Each stored sample is multiplied by its own coefficient, the three products are added, and the upper bits of the sum are registered as the output. The datapath has no controller and no handshake. It runs on every clock.

The three coefficients are run-time writable through a small write port made of a data word, a 2-bit address and a write enable. The address is decoded to one load strobe per coefficient. Address 3 selects nothing. The sum keeps full precision internally and is 26 bits wide. The output keeps its 12 most significant bits, so `result_o = floor(sum / 2^14)`. In this scaling a coefficient value of 4096 would stand for a gain of 0.25, and the three coefficients together can reach a gain of about 0.75.

Top module: `fir3_filter`

## Requirements
- R1: An active-low asynchronous reset clears the delay line, all three coefficients and the output register to zero. After reset the output stays 0 for any samples until a coefficient is written.
- R2: On every rising clock edge, `sample_i` is captured as the newest tap x0. The old x0 moves to x1 and the old x1 moves to x2.
- R3: At each edge, `result_o` is loaded with bits [25:14] of the 26-bit unsigned sum c0·x0 + c1·x1 + c2·x2, using the register values held before that edge. A sample therefore first affects `result_o` at the second edge after it is presented.
- R4: When `coef_we_i` is 1 and `coef_addr_i` is 0, 1 or 2, coefficient c0, c1 or c2 respectively loads `coef_i` at that edge. The other coefficients keep their values.
- R5: When `coef_we_i` is 0, no coefficient changes, whatever the values on `coef_i` and `coef_addr_i`.
- R6: A write with `coef_addr_i` equal to 3 changes no coefficient.
- R7: A single sample of value v followed by zero samples produces, on three consecutive outputs, floor(c0·v/2^14), floor(c1·v/2^14) and floor(c2·v/2^14). The output returns to 0 after that.
- R8: With all coefficients and samples at 4095, the sum does not wrap and the output is 3070.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 12 | Input sample, one per clock, unsigned |
| coef_i | input | 12 | Coefficient write data, unsigned |
| coef_addr_i | input | 2 | Coefficient select: 0 selects c0, 1 selects c1, 2 selects c2, 3 selects nothing |
| coef_we_i | input | 1 | Coefficient write enable |
| result_o | output | 12 | Registered filter output, bits [25:14] of the sum |

## Verification
The assertions check on every cycle that the delay line shifts, that the output equals the truncated weighted sum of the previous cycle's taps and coefficients, and that coefficient storage follows the write rules: an addressed load, no change with the enable low, and no change for address 3. Some properties can only be shown by the bench's scenarios. These are the reset values seen through the output, the impulse response spread over three consecutive outputs, the full-scale value without wrap-around, and long mixed sequences of writes and samples compared against an arithmetic model.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned COEF_W = 12;
  localparam int unsigned TAPS   = 3;

  function automatic int unsigned sum_width(int unsigned dw, int unsigned cw, int unsigned n);
    return dw + cw + $clog2(n);
  endfunction
endpackage

// File: rtl/fir3_coef_bank.sv
module fir3_coef_bank #(
  parameter int unsigned COEF_W = fir3_pkg::COEF_W,
  parameter int unsigned TAPS   = fir3_pkg::TAPS,
  parameter int unsigned ADDR_W = $clog2(TAPS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [COEF_W-1:0]            wdata_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         we_i,
  output logic [TAPS-1:0][COEF_W-1:0]  coef_o
);
  logic [TAPS-1:0] load;

  // decoder: unused addresses match no slot
  for (genvar g = 0; g < TAPS; g++) begin : g_slot
    assign load[g] = we_i && (addr_i == ADDR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      coef_o[g] <= '0;
      else if (load[g]) coef_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/fir3_delay_line.sv
module fir3_delay_line #(
  parameter int unsigned DATA_W = fir3_pkg::DATA_W,
  parameter int unsigned TAPS   = fir3_pkg::TAPS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DATA_W-1:0]            sample_i,
  output logic [TAPS-1:0][DATA_W-1:0]  tap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_o[0] <= '0;
    else         tap_o[0] <= sample_i;
  end

  for (genvar g = 1; g < TAPS; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_o[g] <= '0;
      else         tap_o[g] <= tap_o[g-1];
    end
  end
endmodule

// File: rtl/fir3_mac_tree.sv
module fir3_mac_tree #(
  parameter int unsigned DATA_W = fir3_pkg::DATA_W,
  parameter int unsigned COEF_W = fir3_pkg::COEF_W,
  parameter int unsigned TAPS   = fir3_pkg::TAPS,
  parameter int unsigned SUM_W  = fir3_pkg::sum_width(DATA_W, COEF_W, TAPS)
) (
  input  logic [TAPS-1:0][DATA_W-1:0]  tap_i,
  input  logic [TAPS-1:0][COEF_W-1:0]  coef_i,
  output logic [SUM_W-1:0]             sum_o
);
  localparam int unsigned PROD_W = DATA_W + COEF_W;

  logic [TAPS-1:0][PROD_W-1:0] prod;

  for (genvar g = 0; g < TAPS; g++) begin : g_mul
    assign prod[g] = PROD_W'(tap_i[g]) * PROD_W'(coef_i[g]);
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < int'(TAPS); i++) sum_o = sum_o + SUM_W'(prod[i]);
  end
endmodule

// File: rtl/fir3_filter.sv
module fir3_filter #(
  parameter int unsigned DATA_W = fir3_pkg::DATA_W,
  parameter int unsigned COEF_W = fir3_pkg::COEF_W,
  parameter int unsigned TAPS   = fir3_pkg::TAPS,
  parameter int unsigned ADDR_W = $clog2(TAPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic [ADDR_W-1:0] coef_addr_i,
  input  logic              coef_we_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned SUM_W = fir3_pkg::sum_width(DATA_W, COEF_W, TAPS);

  logic [TAPS-1:0][DATA_W-1:0] tap_q;
  logic [TAPS-1:0][COEF_W-1:0] coef_q;
  logic [SUM_W-1:0]            sum;

  fir3_delay_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample_i),
    .tap_o   (tap_q)
  );

  fir3_coef_bank #(.COEF_W(COEF_W), .TAPS(TAPS), .ADDR_W(ADDR_W)) u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wdata_i(coef_i),
    .addr_i (coef_addr_i),
    .we_i   (coef_we_i),
    .coef_o (coef_q)
  );

  fir3_mac_tree #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .SUM_W(SUM_W)) u_mac (
    .tap_i (tap_q),
    .coef_i(coef_q),
    .sum_o (sum)
  );

  // keep the top DATA_W bits of the full-precision sum
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) result_o <= '0;
    else         result_o <= sum[SUM_W-1 -: DATA_W];
  end
endmodule

// File: rtl/fir3_filter_chk.sv
module fir3_filter_chk #(
  parameter int unsigned DATA_W = fir3_pkg::DATA_W,
  parameter int unsigned COEF_W = fir3_pkg::COEF_W,
  parameter int unsigned TAPS   = fir3_pkg::TAPS,
  parameter int unsigned ADDR_W = $clog2(TAPS + 1)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [DATA_W-1:0]            sample_i,
  input logic [COEF_W-1:0]            coef_i,
  input logic [ADDR_W-1:0]            coef_addr_i,
  input logic                         coef_we_i,
  input logic [DATA_W-1:0]            result_o,
  input logic [TAPS-1:0][DATA_W-1:0]  tap_q,
  input logic [TAPS-1:0][COEF_W-1:0]  coef_q
);
  localparam int unsigned SUM_W = fir3_pkg::sum_width(DATA_W, COEF_W, TAPS);

  logic [63:0] ref_sum;
  always_comb begin
    ref_sum = '0;
    for (int i = 0; i < int'(TAPS); i++) ref_sum = ref_sum + 64'(tap_q[i]) * 64'(coef_q[i]);
  end

  AST_TAP0_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tap_q[0] == $past(sample_i)); // R2

  AST_TAP_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tap_q[TAPS-1:1] == $past(tap_q[TAPS-2:0])); // R2

  AST_RESULT_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> result_o == $past(ref_sum[SUM_W-1 -: DATA_W])); // R3

  AST_COEF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_we_i && coef_addr_i < ADDR_W'(TAPS))
      |=> coef_q[$past(coef_addr_i)] == $past(coef_i)); // R4

  AST_COEF_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !coef_we_i |=> $stable(coef_q)); // R5

  AST_COEF_HOLD_ADDR3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coef_we_i && coef_addr_i == ADDR_W'(3)) |=> $stable(coef_q)); // R6
endmodule

bind fir3_filter fir3_filter_chk #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .ADDR_W(ADDR_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sample_i   (sample_i),
  .coef_i     (coef_i),
  .coef_addr_i(coef_addr_i),
  .coef_we_i  (coef_we_i),
  .result_o   (result_o),
  .tap_q      (tap_q),
  .coef_q     (coef_q)
);

// File: tb/fir3_filter_tb_top.sv
`timescale 1ns/1ps
module fir3_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] sample = '0;
  logic [11:0] coef = '0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [11:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  longint m_x [3];
  longint m_c [3];
  longint m_y;

  always #2.5 clk = ~clk;

  fir3_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .coef_i(coef),
    .coef_addr_i(addr), .coef_we_i(we), .result_o(result)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 3; i++) begin m_x[i] = 0; m_c[i] = 0; end
    m_y = 0;
  endtask

  // one clock: drive at negedge, update model at posedge, compare after it
  task automatic step(input logic [11:0] x, input logic [11:0] c,
                      input logic [1:0] a, input logic w, input string req);
    @(negedge clk);
    sample = x; coef = c; addr = a; we = w;
    @(posedge clk);
    m_y = ((m_c[0]*m_x[0] + m_c[1]*m_x[1] + m_c[2]*m_x[2]) >> 14) & 12'hFFF;
    m_x[2] = m_x[1]; m_x[1] = m_x[0]; m_x[0] = longint'(x);
    if (w && a != 2'd3) m_c[a] = longint'(c);
    #1;
    check(req, longint'(result), m_y);
  endtask

  initial begin
    logic [15:0] lfsr;
    model_clear();
    #1;
    check("R1", longint'(result), 0);
    #10 rst_n = 1'b1;

    // R1: coefficients cleared, output stays 0 for nonzero samples
    for (int i = 0; i < 4; i++) step(12'hFFF, 12'h0, 2'd0, 1'b0, "R1");
    check("R1", longint'(result), 0);

    // R4: load each coefficient
    step(12'd0, 12'd4095, 2'd0, 1'b1, "R4");
    step(12'd0, 12'd2048, 2'd1, 1'b1, "R4");
    step(12'd0, 12'd1024, 2'd2, 1'b1, "R4");
    step(12'd0, 12'd0,    2'd0, 1'b0, "R4");
    step(12'd0, 12'd0,    2'd0, 1'b0, "R4");

    // R7: impulse response, explicit values
    step(12'd4095, 12'd0, 2'd0, 1'b0, "R7");
    check("R7", longint'(result), 0);
    step(12'd0, 12'd0, 2'd0, 1'b0, "R7");
    check("R7", longint'(result), 1023);
    step(12'd0, 12'd0, 2'd0, 1'b0, "R7");
    check("R7", longint'(result), 511);
    step(12'd0, 12'd0, 2'd0, 1'b0, "R7");
    check("R7", longint'(result), 255);
    step(12'd0, 12'd0, 2'd0, 1'b0, "R7");
    check("R7", longint'(result), 0);

    // R5: data and address toggle with enable low
    for (int i = 0; i < 12; i++) step(12'd3000, 12'(i * 97), 2'(i), 1'b0, "R5");
    check("R5", longint'(result), ((4095 + 2048 + 1024) * 3000) >> 14);

    // R6: writes to address 3 are dropped
    for (int i = 0; i < 6; i++) step(12'd3000, 12'd7, 2'd3, 1'b1, "R6");
    check("R6", longint'(result), ((4095 + 2048 + 1024) * 3000) >> 14);

    // R8: full scale
    step(12'd4095, 12'd4095, 2'd1, 1'b1, "R8");
    step(12'd4095, 12'd4095, 2'd2, 1'b1, "R8");
    for (int i = 0; i < 4; i++) step(12'd4095, 12'd0, 2'd0, 1'b0, "R8");
    check("R8", longint'(result), 3070);

    // R2: sweep every sample value through the chain
    for (int v = 0; v < 4096; v++) step(12'(v), 12'd0, 2'd0, 1'b0, "R2");

    // R3: mixed writes and samples
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[11:0], {lfsr[3:0], lfsr[15:8]}, lfsr[13:12], lfsr[4] & lfsr[7], "R3");
    end

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", longint'(result), 0);
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(12'd2222, 12'd0, 2'd0, 1'b0, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule